// File: doc/BRIEF.md
# Supply-Loss Time Capture

This block keeps a record of the calendar time at the moment the main supply drops away and again when it comes back. A clock core supplies the current minutes, hours, day-of-month and month as BCD bytes. A supply-good level comes from an analog trip detector. Two further flags report whether a backup cell is present and whether the oscillator is running. The supply-good level is asynchronous, so it passes through a flip-flop synchronizer before any edge is detected. Each edge triggers exactly one capture.

When the supply fails, the block copies the time into a power-down snapshot and raises a battery-switch flag. When the supply is restored, it copies the time into a separate power-up snapshot. Software reads both snapshots and the flag through a byte-addressed register port. Software clears the flag by writing a zero to it, and that write also erases both snapshots. This arms the block for the next outage.

Top module: `pwr_stamp`

## Requirements
- R1: After reset the battery-switch flag is 0, all eight snapshot bytes read 0, and the status byte at address 0x03 reads 0x00.
- R2: A falling edge of supply-good, while backup is present and the oscillator runs, loads the time into the power-down snapshot. The byte order is 0x18 minutes, 0x19 hours, 0x1A day, 0x1B month. The new values are readable on the third rising clock edge after the input changes.
- R3: The same power-down capture sets the battery-switch flag, which reads as bit 4 of address 0x03.
- R4: A rising edge of supply-good, under the same conditions, loads the time into the power-up snapshot. The byte order is 0x1C minutes, 0x1D hours, 0x1E day, 0x1F month.
- R5: If the backup is absent or the oscillator is stopped when an edge is seen, neither snapshot changes and the flag keeps its value.
- R6: Each edge causes exactly one capture. While supply-good holds its level, later changes of the time do not alter the snapshots.
- R7: A second power-down while the flag is still set overwrites the power-down snapshot with the newer time.
- R8: A write to 0x03 with bit 4 equal to 0 clears the flag and all eight snapshot bytes. A write to 0x03 with bit 4 equal to 1 changes nothing.
- R9: Writes to 0x18 through 0x1F are ignored, and those addresses keep returning the stored bytes.
- R10: Addresses outside 0x03 and 0x18 to 0x1F read 0. The bits of 0x03 other than bit 4 read 0.
- R11: If a clearing write and a capture fall on the same clock edge, the capture wins. On a power-down capture, the flag ends up set, the power-down snapshot holds the new time and the power-up snapshot is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyGood | input | 1 | Asynchronous main-supply-good level, 1 while the supply is above the trip point |
| oscRunning | input | 1 | Oscillator running flag |
| backupPresent | input | 1 | Backup supply present flag |
| timeNow | input | 32 | Current time: byte 0 minutes, byte 1 hours, byte 2 day, byte 3 month (BCD) |
| regAddr | input | 5 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |

## Verification
The hardest case to reach is a software clear that lands on the same clock edge as a capture, because the capture happens two synchronizer stages after the supply input moves. A directed sequence counts edges from the supply change and places the status write on the third one. The random phase toggles supply with randomly withheld backup and oscillator flags and mixes in writes to every address. After each step it reads back the whole register map and compares it against a bench model.

// File: rtl/pwr_stamp_pkg.sv
package pwr_stamp_pkg;

  typedef struct packed {
    logic captDown;
    logic captUp;
    logic clearAll;
  } stampStrobe_t;

endpackage

// File: rtl/pwr_stamp_ctrl.sv
module pwr_stamp_ctrl
  import pwr_stamp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_ADDR = 3,
  parameter int FLAG_BIT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              oscRunning,
  input  logic              backupPresent,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output stampStrobe_t      strobe,
  output logic              batFlag
);

  localparam logic [ADDR_W-1:0] STATUS_SEL = ADDR_W'(STATUS_ADDR);

  // synchronizer chain; resets to "supply good" so no edge fires out of reset
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   supplyPrev;
  logic                   supplyNow;
  logic                   fallSeen;
  logic                   riseSeen;
  logic                   armed;
  logic                   clearReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain  <= '1;
      supplyPrev <= 1'b1;
    end else begin
      syncChain  <= {syncChain[SYNC_STAGES-2:0], supplyGood};
      supplyPrev <= syncChain[SYNC_STAGES-1];
    end
  end

  assign supplyNow = syncChain[SYNC_STAGES-1];
  assign fallSeen  = supplyPrev & ~supplyNow;
  assign riseSeen  = ~supplyPrev & supplyNow;
  assign armed     = backupPresent & oscRunning;
  assign clearReq  = regWrEn && (regAddr == STATUS_SEL) && !regWrData[FLAG_BIT];

  always_comb begin
    strobe.captDown = fallSeen & armed;
    strobe.captUp   = riseSeen & armed;
    strobe.clearAll = clearReq;
  end

  // capture outranks a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      batFlag <= 1'b0;
    end else if (strobe.captDown) begin
      batFlag <= 1'b1;
    end else if (strobe.clearAll) begin
      batFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_stamp_dp.sv
module pwr_stamp_dp
  import pwr_stamp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int STAMP_BYTES = 4,
  parameter int STATUS_ADDR = 3,
  parameter int FLAG_BIT    = 4,
  parameter int DOWN_BASE   = 24,
  parameter int UP_BASE     = 28
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  stampStrobe_t                  strobe,
  input  logic                          batFlag,
  input  logic [STAMP_BYTES*DATA_W-1:0] timeNow,
  input  logic [ADDR_W-1:0]             regAddr,
  output logic [DATA_W-1:0]             regRdData
);

  localparam logic [ADDR_W-1:0] STATUS_SEL = ADDR_W'(STATUS_ADDR);

  logic [DATA_W-1:0] downSnap [STAMP_BYTES];
  logic [DATA_W-1:0] upSnap   [STAMP_BYTES];

  for (genvar g = 0; g < STAMP_BYTES; g++) begin : gSnap
    always_ff @(posedge clk) begin
      if (!rstN) begin
        downSnap[g] <= '0;
      end else if (strobe.captDown) begin
        downSnap[g] <= timeNow[g*DATA_W +: DATA_W];
      end else if (strobe.clearAll) begin
        downSnap[g] <= '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        upSnap[g] <= '0;
      end else if (strobe.captUp) begin
        upSnap[g] <= timeNow[g*DATA_W +: DATA_W];
      end else if (strobe.clearAll) begin
        upSnap[g] <= '0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == STATUS_SEL) begin
      regRdData[FLAG_BIT] = batFlag;
    end
    for (int i = 0; i < STAMP_BYTES; i++) begin
      if (regAddr == ADDR_W'(DOWN_BASE + i)) regRdData = downSnap[i];
      if (regAddr == ADDR_W'(UP_BASE + i))   regRdData = upSnap[i];
    end
  end

endmodule

// File: rtl/pwr_stamp.sv
module pwr_stamp
  import pwr_stamp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAMP_BYTES = 4,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_ADDR = 3,
  parameter int FLAG_BIT    = 4,
  parameter int DOWN_BASE   = 24,
  parameter int UP_BASE     = 28
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          supplyGood,
  input  logic                          oscRunning,
  input  logic                          backupPresent,
  input  logic [STAMP_BYTES*DATA_W-1:0] timeNow,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic [DATA_W-1:0]             regWrData,
  output logic [DATA_W-1:0]             regRdData
);

  stampStrobe_t strobe;
  logic         batFlag;

  pwr_stamp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
    .STATUS_ADDR(STATUS_ADDR), .FLAG_BIT(FLAG_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .oscRunning(oscRunning), .backupPresent(backupPresent),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .strobe(strobe), .batFlag(batFlag)
  );

  pwr_stamp_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAMP_BYTES(STAMP_BYTES),
    .STATUS_ADDR(STATUS_ADDR), .FLAG_BIT(FLAG_BIT),
    .DOWN_BASE(DOWN_BASE), .UP_BASE(UP_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .batFlag(batFlag),
    .timeNow(timeNow), .regAddr(regAddr), .regRdData(regRdData)
  );

endmodule

// File: rtl/pwr_stamp_chk.sv
module pwr_stamp_chk #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 3,
  parameter int FLAG_BIT    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              batFlag,
  input logic              captDown,
  input logic              captUp,
  input logic              backupPresent,
  input logic              oscRunning,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData
);

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    captDown |=> batFlag);

  // R5
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(batFlag) |-> $past(backupPresent && oscRunning));

  // R6
  one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (captDown || captUp) |=> !(captDown || captUp));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(STATUS_ADDR) && !regWrData[FLAG_BIT] && !captDown)
      |=> !batFlag);

  // R11
  capt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (captDown && regWrEn && regAddr == ADDR_W'(STATUS_ADDR)) |=> batFlag);

  // R6
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(captDown && captUp));

endmodule

bind pwr_stamp pwr_stamp_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .batFlag(batFlag),
  .captDown(strobe.captDown), .captUp(strobe.captUp),
  .backupPresent(backupPresent), .oscRunning(oscRunning),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData)
);

// File: tb/pwr_stamp_tb.sv
module pwr_stamp_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supplyGood = 1'b1;
  logic        oscRunning = 1'b1;
  logic        backupPresent = 1'b1;
  logic [31:0] timeNow = '0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;

  int testCnt = 0;
  int failCnt = 0;

  // bench model
  logic [7:0] expDown [4];
  logic [7:0] expUp   [4];
  logic       expFlag;
  logic       curSupply;

  always #4 clk = ~clk;

  pwr_stamp u_dut (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .oscRunning(oscRunning), .backupPresent(backupPresent),
    .timeNow(timeNow), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [7:0] stampByte(logic [31:0] t, int i);
    return t[i*8 +: 8];
  endfunction

  function automatic logic [7:0] expRead(logic [4:0] a);
    if (a == 5'h03) return {3'b000, expFlag, 4'b0000};
    if (a >= 5'h18 && a <= 5'h1B) return expDown[a - 5'h18];
    if (a >= 5'h1C) return expUp[a - 5'h1C];
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [4:0] a, logic [7:0] act, logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s addr %02h actual %02h expected %02h", req, a, act, exp);
    end
  endtask

  task automatic readChk(string req, logic [4:0] a);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, a, regRdData, expRead(a));
  endtask

  task automatic checkMap(string req);
    readChk(req, 5'h03);
    for (int i = 0; i < 8; i++) readChk(req, 5'(8'h18 + i));
  endtask

  task automatic modelClear();
    expFlag = 1'b0;
    for (int i = 0; i < 4; i++) begin
      expDown[i] = '0;
      expUp[i] = '0;
    end
  endtask

  task automatic regWrite(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 5'h03 && !d[4]) modelClear();
  endtask

  task automatic supplyEvent(logic lvl, logic bk, logic osc, logic [31:0] t);
    @(negedge clk);
    supplyGood = lvl; backupPresent = bk; oscRunning = osc; timeNow = t;
    repeat (3) @(posedge clk);
    if (lvl != curSupply && bk && osc) begin
      for (int i = 0; i < 4; i++) begin
        if (!lvl) expDown[i] = stampByte(t, i);
        else      expUp[i]   = stampByte(t, i);
      end
      if (!lvl) expFlag = 1'b1;
    end
    curSupply = lvl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] t;
    logic [7:0]  d;
    logic [4:0]  a;
    int          op;
    int          seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    modelClear();
    curSupply = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    checkMap("R1");
    readChk("R10", 5'h00);

    // R2 R3 power-down capture
    supplyEvent(1'b0, 1'b1, 1'b1, 32'h12_25_17_45);
    checkMap("R2 R3");

    // R6 time moves while supply stays low
    @(negedge clk) timeNow = 32'h12_25_17_59;
    repeat (10) @(posedge clk);
    checkMap("R6");

    // R4 power-up capture
    supplyEvent(1'b1, 1'b1, 1'b1, 32'h12_25_18_02);
    checkMap("R4");

    // R10 unmapped and status spare bits
    readChk("R10", 5'h04);
    readChk("R10", 5'h17);
    readChk("R10", 5'h03);

    // R9 writes to snapshot bytes ignored
    regWrite(5'h18, 8'hAA);
    regWrite(5'h1F, 8'h55);
    checkMap("R9");

    // R8 write with bit 4 set changes nothing
    regWrite(5'h03, 8'hFF);
    checkMap("R8");

    // R7 second power-down overwrites
    supplyEvent(1'b0, 1'b1, 1'b1, 32'h01_02_03_04);
    supplyEvent(1'b1, 1'b1, 1'b1, 32'h01_02_03_09);
    supplyEvent(1'b0, 1'b1, 1'b1, 32'h01_02_04_30);
    checkMap("R7");

    // R8 clear erases everything
    regWrite(5'h03, 8'hEF);
    checkMap("R8");

    // R5 gating by backup and oscillator
    supplyEvent(1'b1, 1'b0, 1'b1, 32'h09_09_09_09);
    supplyEvent(1'b0, 1'b1, 1'b0, 32'h08_08_08_08);
    checkMap("R5");
    supplyEvent(1'b1, 1'b1, 1'b1, 32'h07_07_07_07);
    regWrite(5'h1C, 8'h00);
    checkMap("R4 R9");

    // R11 clear on the same edge as a power-down capture
    @(negedge clk);
    supplyGood = 1'b0; timeNow = 32'h11_30_23_59;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = 5'h03; regWrData = 8'h00; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk) regWrEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      expUp[i] = '0;
      expDown[i] = stampByte(32'h11_30_23_59, i);
    end
    expFlag = 1'b1;
    curSupply = 1'b0;
    checkMap("R11");

    // random phase
    for (int n = 0; n < 250; n++) begin
      op = $urandom_range(0, 9);
      t = $urandom;
      if (op < 4) begin
        supplyEvent(~curSupply, ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0), t);
      end else if (op < 6) begin
        @(negedge clk) timeNow = t;
        repeat ($urandom_range(1, 4)) @(posedge clk);
      end else begin
        d = 8'($urandom);
        case ($urandom_range(0, 2))
          0:       a = 5'h03;
          1:       a = 5'(8'h18 + $urandom_range(0, 7));
          default: a = 5'($urandom);
        endcase
        regWrite(a, d);
      end
      checkMap("R2 R4 R5 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule